// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This unit sits next to the physical interface and records when precision-time event messages cross the wire. It keeps a 64-bit free-running time base that grows by a programmable step on every clock. It also watches two start-of-frame strobes, one for each direction. Each strobe comes with a message type that an upstream parser has already decoded.

The node's current clock role decides which messages are stamped. In the master role, the unit stamps outgoing sync messages and incoming delay requests. In the slave role, it stamps incoming sync messages and outgoing delay requests. Each direction has one holding slot. A captured value stays in its slot until software clears it. A capture that arrives while the slot is occupied is dropped and recorded in a sticky overflow flag. Capture is armed only when the link runs full duplex and the extended descriptor format is switched on.

Each holding slot is a small state machine with three states:
- EMPTY: nothing held.
- HELD: a stamp is held.
- LOST: a stamp is held and at least one later capture was dropped.

Its transitions are:
- capture (EMPTY to HELD)
- miss (HELD to LOST)
- release (HELD or LOST to EMPTY on clear)
- reload (HELD or LOST to HELD when a clear and a capture coincide)

Top module: `ptp_stamp_unit`

## Requirements
- R1: `time_now` is zero during reset. On every clock edge after reset it increases by the value on `time_inc` (modulo 2^64).
- R2: In the master role (`role`=0), a transmit strobe tagged sync (code 0) captures into the transmit slot.
- R3: In the master role, a receive strobe tagged delay request (code 1) captures into the receive slot. A receive sync and a transmit delay request capture nothing.
- R4: In the slave role (`role`=1), a receive strobe tagged sync captures into the receive slot. A receive delay request captures nothing.
- R5: In the slave role, a transmit strobe tagged delay request captures into the transmit slot. A transmit sync captures nothing.
- R6: Message codes 2 (follow-up), 3 (delay response) and 4 to 7 (other) never capture, in either role or direction.
- R7: No capture takes place while `full_duplex` is 0 or `ext_desc_en` is 0.
- R8: A capture stores the `time_now` value of the cycle in which the strobe is high. The slot's valid flag and stamp show it one clock later.
- R9: While a slot is valid, a further qualifying strobe leaves the stamp unchanged and sets that slot's overflow flag. The overflow flag stays set until the slot is cleared.
- R10: A clear pulse on `tx_clr`/`rx_clr` with no capture in the same cycle empties the slot: valid and overflow read 0 on the next clock.
- R11: A clear and a qualifying strobe in the same cycle leave the slot valid with the new stamp and overflow at 0.
- R12: Reset empties both slots: valid, overflow and stamps read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_inc | input | 32 | Step added to the time base each clock |
| full_duplex | input | 1 | Link is full duplex (capture gate) |
| ext_desc_en | input | 1 | Extended descriptor format on (capture gate) |
| role | input | 1 | 0 = master, 1 = slave |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_msg | input | 3 | Transmit message code |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_msg | input | 3 | Receive message code |
| tx_clr | input | 1 | Software clear of the transmit slot |
| rx_clr | input | 1 | Software clear of the receive slot |
| time_now | output | 64 | Current time base value |
| tx_valid | output | 1 | Transmit slot holds a stamp |
| tx_stamp | output | 64 | Transmit slot stamp |
| tx_ovf | output | 1 | Transmit capture was dropped while full |
| rx_valid | output | 1 | Receive slot holds a stamp |
| rx_stamp | output | 64 | Receive slot stamp |
| rx_ovf | output | 1 | Receive capture was dropped while full |

## Verification
The bench walks the full role-by-direction-by-message matrix. A design with the role decode swapped or the directions crossed would stamp the wrong side or nothing at all.

It compares each stamp with the time value seen in the strobe cycle. An extra register stage would shift the stamp by one time step, and a missing one would show valid a cycle early.

It fires a second capture into a full slot, and then a clear together with a capture. An overwriting design would lose the first stamp. A design that gives clear priority would come back empty instead of holding the fresh value.

Finally, it changes the time step mid-run. This exposes a time base that ignores its programmed increment.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

    typedef enum logic [2:0] {
        MSG_SYNC   = 3'd0,
        MSG_DREQ   = 3'd1,
        MSG_FOLLOW = 3'd2,
        MSG_DRESP  = 3'd3,
        MSG_OTHER  = 3'd4
    } msg_t;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_t;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_HELD  = 2'd1,
        SLOT_LOST  = 2'd2
    } slot_t;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int NUM_DIR = 2;

endpackage

// File: rtl/ptp_time_base.sv
module ptp_time_base #(
    parameter int TIME_W = 64,
    parameter int INC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  inc,
    output logic [TIME_W-1:0] now
);
    localparam int PAD_W = TIME_W - INC_W;

    logic [TIME_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + {{PAD_W{1'b0}}, inc};
        end
    end

    assign now = count_q;
endmodule

// File: rtl/ptp_event_filter.sv
module ptp_event_filter
    import ptp_stamp_pkg::*;
#(
    parameter int DIR   = DIR_TX,
    parameter int MSG_W = 3
) (
    input  logic             sof,
    input  logic [MSG_W-1:0] msg,
    input  logic             role,
    input  logic             full_duplex,
    input  logic             ext_desc_en,
    output logic             hit
);
    logic             sync_side;
    logic [MSG_W-1:0] wanted;

    // Sync is stamped where the master sends it or the slave receives it;
    // the opposite path carries the stamped delay request.
    always_comb begin
        sync_side = ((role == ROLE_MASTER) == (DIR == DIR_TX));
        wanted    = sync_side ? MSG_W'(MSG_SYNC) : MSG_W'(MSG_DREQ);
    end

    assign hit = sof && full_duplex && ext_desc_en && (msg == wanted);
endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot
    import ptp_stamp_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              clr,
    input  logic [TIME_W-1:0] time_in,
    output logic              valid,
    output logic [TIME_W-1:0] stamp,
    output logic              ovf
);
    slot_t             state_q, state_d;
    logic              load;
    logic [TIME_W-1:0] stamp_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (hit) state_d = SLOT_HELD;                      // capture
            end
            SLOT_HELD: begin
                if (clr) state_d = hit ? SLOT_HELD : SLOT_EMPTY;   // reload / release
                else if (hit) state_d = SLOT_LOST;                 // miss
            end
            SLOT_LOST: begin
                if (clr) state_d = hit ? SLOT_HELD : SLOT_EMPTY;   // reload / release
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    assign load = hit && ((state_q == SLOT_EMPTY) || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp_q <= '0;
        end else if (load) begin
            stamp_q <= time_in;
        end
    end

    // outputs
    always_comb begin
        valid = 1'b0;
        ovf   = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: ;
            SLOT_HELD:  valid = 1'b1;
            SLOT_LOST: begin
                valid = 1'b1;
                ovf   = 1'b1;
            end
            default: ;
        endcase
        stamp = stamp_q;
    end
endmodule

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit
    import ptp_stamp_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int INC_W  = 32,
    parameter int MSG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  time_inc,
    input  logic              full_duplex,
    input  logic              ext_desc_en,
    input  logic              role,
    input  logic              tx_sof,
    input  logic [MSG_W-1:0]  tx_msg,
    input  logic              rx_sof,
    input  logic [MSG_W-1:0]  rx_msg,
    input  logic              tx_clr,
    input  logic              rx_clr,
    output logic [TIME_W-1:0] time_now,
    output logic              tx_valid,
    output logic [TIME_W-1:0] tx_stamp,
    output logic              tx_ovf,
    output logic              rx_valid,
    output logic [TIME_W-1:0] rx_stamp,
    output logic              rx_ovf
);
    logic [NUM_DIR-1:0] sof_v, clr_v, hit_v, valid_v, ovf_v;
    logic [MSG_W-1:0]   msg_v   [NUM_DIR];
    logic [TIME_W-1:0]  stamp_v [NUM_DIR];

    ptp_time_base #(.TIME_W(TIME_W), .INC_W(INC_W)) u_time (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (time_inc),
        .now  (time_now)
    );

    assign sof_v[DIR_TX] = tx_sof;
    assign sof_v[DIR_RX] = rx_sof;
    assign clr_v[DIR_TX] = tx_clr;
    assign clr_v[DIR_RX] = rx_clr;
    assign msg_v[DIR_TX] = tx_msg;
    assign msg_v[DIR_RX] = rx_msg;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        ptp_event_filter #(.DIR(d), .MSG_W(MSG_W)) u_filter (
            .sof        (sof_v[d]),
            .msg        (msg_v[d]),
            .role       (role),
            .full_duplex(full_duplex),
            .ext_desc_en(ext_desc_en),
            .hit        (hit_v[d])
        );

        ptp_stamp_slot #(.TIME_W(TIME_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit_v[d]),
            .clr    (clr_v[d]),
            .time_in(time_now),
            .valid  (valid_v[d]),
            .stamp  (stamp_v[d]),
            .ovf    (ovf_v[d])
        );
    end

    assign tx_valid = valid_v[DIR_TX];
    assign tx_stamp = stamp_v[DIR_TX];
    assign tx_ovf   = ovf_v[DIR_TX];
    assign rx_valid = valid_v[DIR_RX];
    assign rx_stamp = stamp_v[DIR_RX];
    assign rx_ovf   = ovf_v[DIR_RX];
endmodule

// File: rtl/ptp_stamp_checks.sv
module ptp_stamp_checks #(
    parameter int TIME_W = 64,
    parameter int INC_W  = 32,
    parameter int MSG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [INC_W-1:0]  time_inc,
    input logic              full_duplex,
    input logic              ext_desc_en,
    input logic              role,
    input logic              tx_sof,
    input logic [MSG_W-1:0]  tx_msg,
    input logic              rx_sof,
    input logic [MSG_W-1:0]  rx_msg,
    input logic              tx_clr,
    input logic              rx_clr,
    input logic [TIME_W-1:0] time_now,
    input logic              tx_valid,
    input logic [TIME_W-1:0] tx_stamp,
    input logic              tx_ovf,
    input logic              rx_valid,
    input logic [TIME_W-1:0] rx_stamp,
    input logic              rx_ovf
);
    a_r1_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> time_now == $past(time_now) + TIME_W'($past(time_inc)));

    a_r8_tx_master_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof && tx_msg == MSG_W'(0) && !role && full_duplex && ext_desc_en && !tx_valid)
        |=> (tx_valid && tx_stamp == $past(time_now)));

    a_r8_rx_slave_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && rx_msg == MSG_W'(0) && role && full_duplex && ext_desc_en && !rx_valid)
        |=> (rx_valid && rx_stamp == $past(time_now)));

    a_r7_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((!full_duplex || !ext_desc_en) && !tx_valid) |=> !tx_valid);

    a_r7_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((!full_duplex || !ext_desc_en) && !rx_valid) |=> !rx_valid);

    a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_clr) |=> (tx_valid && $stable(tx_stamp)));

    a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_clr) |=> (rx_valid && $stable(rx_stamp)));

    a_r9_tx_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !tx_clr) |=> tx_ovf);

    a_r9_ovf_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf |-> tx_valid) and (rx_ovf |-> rx_valid));

    a_r10_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !tx_sof) |=> (!tx_valid && !tx_ovf));

    a_r10_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_sof) |=> (!rx_valid && !rx_ovf));

    a_r11_tx_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && tx_sof && tx_msg == MSG_W'(0) && !role && full_duplex && ext_desc_en)
        |=> (tx_valid && !tx_ovf && tx_stamp == $past(time_now)));
endmodule

bind ptp_stamp_unit ptp_stamp_checks #(
    .TIME_W(TIME_W), .INC_W(INC_W), .MSG_W(MSG_W)
) u_checks (.*);

// File: tb/ptp_stamp_unit_tb.sv
module ptp_stamp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] time_inc = 32'd8;
    logic        full_duplex = 1'b1;
    logic        ext_desc_en = 1'b1;
    logic        role = 1'b0;
    logic        tx_sof = 1'b0, rx_sof = 1'b0;
    logic [2:0]  tx_msg = 3'd0, rx_msg = 3'd0;
    logic        tx_clr = 1'b0, rx_clr = 1'b0;
    logic [63:0] time_now, tx_stamp, rx_stamp;
    logic        tx_valid, tx_ovf, rx_valid, rx_ovf;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ptp_stamp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .time_inc(time_inc),
        .full_duplex(full_duplex), .ext_desc_en(ext_desc_en), .role(role),
        .tx_sof(tx_sof), .tx_msg(tx_msg), .rx_sof(rx_sof), .rx_msg(rx_msg),
        .tx_clr(tx_clr), .rx_clr(rx_clr), .time_now(time_now),
        .tx_valid(tx_valid), .tx_stamp(tx_stamp), .tx_ovf(tx_ovf),
        .rx_valid(rx_valid), .rx_stamp(rx_stamp), .rx_ovf(rx_ovf)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; returns the time seen in the strobe cycle.
    task automatic pulse(input bit is_tx, input logic [2:0] code, output logic [63:0] t);
        if (is_tx) begin tx_sof = 1'b1; tx_msg = code; end
        else       begin rx_sof = 1'b1; rx_msg = code; end
        t = time_now;
        @(negedge clk);
        tx_sof = 1'b0;
        rx_sof = 1'b0;
    endtask

    task automatic clear_both();
        tx_clr = 1'b1; rx_clr = 1'b1;
        @(negedge clk);
        tx_clr = 1'b0; rx_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 tx_valid", 64'(tx_valid), 64'd0);
        check("R12 rx_valid", 64'(rx_valid), 64'd0);
        check("R12 ovf", 64'({tx_ovf, rx_ovf}), 64'd0);
        check("R12 tx_stamp", tx_stamp, 64'd0);
        check("R12 rx_stamp", rx_stamp, 64'd0);
        check("R1 reset time", time_now, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_time_base();
        logic [63:0] a;
        a = time_now;
        @(negedge clk);
        check("R1 step 8", time_now, a + 64'd8);
        time_inc = 32'd3;
        a = time_now;
        @(negedge clk);
        check("R1 step 3", time_now, a + 64'd3);
        a = time_now;
        repeat (4) @(negedge clk);
        check("R1 four steps", time_now, a + 64'd12);
        time_inc = 32'd7;
    endtask

    task automatic t_master();
        logic [63:0] t;
        role = 1'b0;
        clear_both();
        pulse(1'b1, 3'd0, t);
        check("R2 master tx sync valid", 64'(tx_valid), 64'd1);
        check("R8 master tx sync stamp", tx_stamp, t);
        check("R2 rx untouched", 64'(rx_valid), 64'd0);
        clear_both();
        pulse(1'b0, 3'd0, t);
        check("R3 master rx sync ignored", 64'(rx_valid), 64'd0);
        pulse(1'b1, 3'd1, t);
        check("R3 master tx dreq ignored", 64'(tx_valid), 64'd0);
        pulse(1'b0, 3'd1, t);
        check("R3 master rx dreq valid", 64'(rx_valid), 64'd1);
        check("R8 master rx dreq stamp", rx_stamp, t);
    endtask

    task automatic t_slave();
        logic [63:0] t;
        role = 1'b1;
        clear_both();
        pulse(1'b1, 3'd0, t);
        check("R5 slave tx sync ignored", 64'(tx_valid), 64'd0);
        pulse(1'b0, 3'd1, t);
        check("R4 slave rx dreq ignored", 64'(rx_valid), 64'd0);
        pulse(1'b0, 3'd0, t);
        check("R4 slave rx sync valid", 64'(rx_valid), 64'd1);
        check("R4 slave rx sync stamp", rx_stamp, t);
        pulse(1'b1, 3'd1, t);
        check("R5 slave tx dreq valid", 64'(tx_valid), 64'd1);
        check("R5 slave tx dreq stamp", tx_stamp, t);
    endtask

    task automatic t_other_msgs();
        logic [63:0] t;
        for (int r = 0; r < 2; r++) begin
            role = r[0];
            clear_both();
            for (int m = 2; m < 8; m++) begin
                pulse(1'b1, 3'(m), t);
                pulse(1'b0, 3'(m), t);
            end
            check("R6 non-event tx", 64'({tx_valid, tx_ovf}), 64'd0);
            check("R6 non-event rx", 64'({rx_valid, rx_ovf}), 64'd0);
        end
    endtask

    task automatic t_gating();
        logic [63:0] t;
        role = 1'b0;
        clear_both();
        full_duplex = 1'b0;
        pulse(1'b1, 3'd0, t);
        pulse(1'b0, 3'd1, t);
        check("R7 half duplex", 64'({tx_valid, rx_valid}), 64'd0);
        full_duplex = 1'b1;
        ext_desc_en = 1'b0;
        pulse(1'b1, 3'd0, t);
        pulse(1'b0, 3'd1, t);
        check("R7 legacy descriptors", 64'({tx_valid, rx_valid}), 64'd0);
        ext_desc_en = 1'b1;
    endtask

    task automatic t_hold_overflow();
        logic [63:0] t1, t2;
        role = 1'b0;
        clear_both();
        pulse(1'b1, 3'd0, t1);
        check("R9 first capture ovf", 64'(tx_ovf), 64'd0);
        repeat (2) @(negedge clk);
        pulse(1'b1, 3'd0, t2);
        check("R9 stamp kept", tx_stamp, t1);
        check("R9 ovf set", 64'(tx_ovf), 64'd1);
        repeat (3) @(negedge clk);
        check("R9 ovf sticky", 64'({tx_valid, tx_ovf}), 64'd3);
        check("R9 rx unaffected", 64'(rx_ovf), 64'd0);
    endtask

    task automatic t_clear();
        tx_clr = 1'b1;
        @(negedge clk);
        tx_clr = 1'b0;
        check("R10 clear valid", 64'(tx_valid), 64'd0);
        check("R10 clear ovf", 64'(tx_ovf), 64'd0);
    endtask

    task automatic t_clear_with_hit();
        logic [63:0] t;
        role = 1'b0;
        pulse(1'b1, 3'd0, t);
        pulse(1'b1, 3'd0, t);
        check("R11 setup ovf", 64'(tx_ovf), 64'd1);
        tx_clr = 1'b1;
        pulse(1'b1, 3'd0, t);
        tx_clr = 1'b0;
        check("R11 reload valid", 64'(tx_valid), 64'd1);
        check("R11 reload stamp", tx_stamp, t);
        check("R11 reload ovf", 64'(tx_ovf), 64'd0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_time_base();
        t_master();
        t_slave();
        t_other_msgs();
        t_gating();
        t_hold_overflow();
        t_clear();
        t_clear_with_hit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule